// File: doc/BRIEF.md
# Differential Quadrature Phase Symbol Encoder

This block takes a serial transmit bit stream, groups the bits into pairs and turns each pair into a phase step. It adds that step to a running carrier phase, so every symbol depends on both the new pair and the phase sent before it. The phase is held as a 3-bit index in steps of 45 degrees. It is presented both as that index and as signed in-phase and quadrature levels, which feed a later pulse-shaping stage.

A run-time mode input picks one of two variants. In the pi/4-shifted variant every step is an odd multiple of 45 degrees. In the plain variant every step is a multiple of 90 degrees and the phase stays on even indices. A test input replaces the user data with an internal pseudo-random sequence. A rate input picks one of two fixed bit periods, counted in master clocks. An active-low reset clears all state and holds it cleared.

Data enters at a fixed rate and leaves at a fixed rate, so there is no ready signal in either direction. The source must present a new bit after each `bit_req` pulse. The sink must accept every `sym_stb` pulse, because the block has no back-pressure and drops nothing.

Top module: `dqpsk_symbol_encoder`

## Requirements
- R1: While `rst_n` is low, `phase_idx` is 0, `sym_stb` is 0 and `bit_req` is 0. After release the levels read I=+1, Q=0.
- R2: `bit_req` is a one-cycle pulse that repeats every SHORT_CLKS cycles when `slow_rate` is 0 and every LONG_CLKS cycles when it is 1. The first pulse comes in the first cycle after reset release.
- R3: The data bit is sampled only at the clock edge that ends cycle P/2 of the bit period, where the `bit_req` cycle is cycle 0 and P is the period. Its value at other cycles has no effect.
- R4: Bits are paired in arrival order, the first as X and the second as Y. `sym_stb` pulses for exactly one cycle, in the cycle right after Y is sampled, and `phase_idx` changes only in such a cycle.
- R5: With `pi4_mode`=1 when Y is sampled, the pair {X,Y} adds to the phase index, modulo 8: 00 adds +1, 01 adds +3, 11 adds -3 and 10 adds -1.
- R6: With `pi4_mode`=0, the new index is the old index with bit 0 cleared, plus 0 for pair 00, +2 for 01, +4 for 11 and -2 for 10. A plain-mode symbol is therefore always even.
- R7: Levels are 2-bit two's complement (+1=01, 0=00, -1=11). For index 0..7 the value of I is +1,+1,0,-1,-1,-1,0,+1 and the value of Q is 0,+1,+1,+1,0,-1,-1,-1.
- R8: With `prbs_mode`=1, `data_in` is ignored and each bit is the MSB of a 9-bit register. The register is set to all ones at reset and shifts left once per bit period, in either mode, taking in bit8 XOR bit4 (x^9+x^5+1).
- R9: A reset mid-stream clears the phase, restarts pairing with the next bit as X and reseeds the sequence generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset / power-down |
| data_in | input | 1 | Serial user data |
| pi4_mode | input | 1 | 1: pi/4-shifted steps, 0: plain steps |
| prbs_mode | input | 1 | 1: encode the internal pseudo-random bits |
| slow_rate | input | 1 | 1: long bit period, 0: short bit period |
| bit_req | output | 1 | Pulse: the source presents the next bit |
| sym_stb | output | 1 | Pulse: a new symbol is on the outputs |
| phase_idx | output | 3 | Carrier phase in 45-degree units |
| i_lvl | output | 2 | Signed in-phase level |
| q_lvl | output | 2 | Signed quadrature level |

## Verification
The bench builds the block with SHORT_CLKS=8 and LONG_CLKS=24 in place of 40 and 320. With these values both bit rates, a full trip of the phase around all eight indices, and a long run of pseudo-random bits fit in a few thousand cycles. Because P/2 is small, the bench can drive the correct bit for exactly one cycle and show that sampling happens at that single edge. The sequence-generator parameters stay at their defaults, so the real polynomial is what the bench checks.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;
  typedef logic [2:0] phase_t;
  typedef logic signed [1:0] lvl_t;

  // phase step for bit pair {x,y}; pi4 picks odd steps, else even steps
  function automatic phase_t pair_step(input logic x, input logic y, input logic pi4);
    phase_t s;
    unique case ({x, y})
      2'b00: s = pi4 ? 3'd1 : 3'd0;
      2'b01: s = pi4 ? 3'd3 : 3'd2;
      2'b11: s = pi4 ? 3'd5 : 3'd4;
      default: s = pi4 ? 3'd7 : 3'd6;
    endcase
    return s;
  endfunction

  function automatic lvl_t cos_lvl(input phase_t p);
    lvl_t v;
    unique case (p)
      3'd0, 3'd1, 3'd7: v = 2'sb01;
      3'd2, 3'd6:       v = 2'sb00;
      default:          v = 2'sb11;
    endcase
    return v;
  endfunction

  function automatic lvl_t sin_lvl(input phase_t p);
    lvl_t v;
    unique case (p)
      3'd1, 3'd2, 3'd3: v = 2'sb01;
      3'd0, 3'd4:       v = 2'sb00;
      default:          v = 2'sb11;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/dqpsk_bit_timer.sv
module dqpsk_bit_timer #(
  parameter int SHORT_CLKS = 40,
  parameter int LONG_CLKS  = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_rate,
  output logic bit_req,
  output logic sample_stb
);
  localparam int MAXC = (LONG_CLKS > SHORT_CLKS) ? LONG_CLKS : SHORT_CLKS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CLKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CLKS - 1);
  localparam logic [CW-1:0] SHORT_MID  = CW'(SHORT_CLKS / 2);
  localparam logic [CW-1:0] LONG_MID   = CW'(LONG_CLKS / 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_q;
  logic [CW-1:0] mid_q;

  assign last_q = slow_rate ? LONG_LAST : SHORT_LAST;
  assign mid_q  = slow_rate ? LONG_MID  : SHORT_MID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cnt >= last_q) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign bit_req    = rst_n && (cnt == '0);
  assign sample_stb = rst_n && (cnt == mid_q);
endmodule

// File: rtl/dqpsk_prbs.sv
module dqpsk_prbs #(
  parameter int WIDTH = 9,
  parameter int TAP   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic bit_out
);
  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '1;
    else if (advance) sr <= {sr[WIDTH-2:0], sr[WIDTH-1] ^ sr[TAP-1]};
  end

  assign bit_out = sr[WIDTH-1];
endmodule

// File: rtl/dqpsk_phase_acc.sv
module dqpsk_phase_acc
  import dqpsk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_stb,
  input  logic   bit_in,
  input  logic   pi4,
  output phase_t phase,
  output logic   sym_stb
);
  logic   have_x;
  logic   x_hold;
  phase_t base;

  // plain mode realigns to an even index before stepping
  assign base = pi4 ? phase : {phase[2:1], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_x  <= 1'b0;
      x_hold  <= 1'b0;
      phase   <= '0;
      sym_stb <= 1'b0;
    end else begin
      sym_stb <= 1'b0;
      if (bit_stb) begin
        if (!have_x) begin
          x_hold <= bit_in;
          have_x <= 1'b1;
        end else begin
          have_x  <= 1'b0;
          phase   <= base + pair_step(x_hold, bit_in, pi4);
          sym_stb <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dqpsk_symbol_encoder.sv
module dqpsk_symbol_encoder
  import dqpsk_pkg::*;
#(
  parameter int SHORT_CLKS = 40,
  parameter int LONG_CLKS  = 320,
  parameter int PRBS_W     = 9,
  parameter int PRBS_TAP   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_in,
  input  logic       pi4_mode,
  input  logic       prbs_mode,
  input  logic       slow_rate,
  output logic       bit_req,
  output logic       sym_stb,
  output logic [2:0] phase_idx,
  output logic [1:0] i_lvl,
  output logic [1:0] q_lvl
);
  logic   sample_stb;
  logic   prbs_bit;
  logic   enc_bit;
  phase_t phase;

  dqpsk_bit_timer #(.SHORT_CLKS(SHORT_CLKS), .LONG_CLKS(LONG_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .slow_rate(slow_rate),
    .bit_req(bit_req), .sample_stb(sample_stb)
  );

  dqpsk_prbs #(.WIDTH(PRBS_W), .TAP(PRBS_TAP)) u_prbs (
    .clk(clk), .rst_n(rst_n), .advance(sample_stb), .bit_out(prbs_bit)
  );

  assign enc_bit = prbs_mode ? prbs_bit : data_in;

  dqpsk_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n), .bit_stb(sample_stb), .bit_in(enc_bit),
    .pi4(pi4_mode), .phase(phase), .sym_stb(sym_stb)
  );

  assign phase_idx = phase;
  assign i_lvl     = cos_lvl(phase);
  assign q_lvl     = sin_lvl(phase);
endmodule

// File: rtl/dqpsk_symbol_encoder_chk.sv
module dqpsk_symbol_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pi4_mode,
  input logic       bit_req,
  input logic       sym_stb,
  input logic [2:0] phase_idx,
  input logic [1:0] i_lvl,
  input logic [1:0] q_lvl
);
  logic prev_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_odd <= 1'b0;
    else if (sym_stb) prev_odd <= phase_idx[0];
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (phase_idx == 3'd0 && !sym_stb && !bit_req));

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> !bit_req);

  p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> !sym_stb);

  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |-> $stable(phase_idx));

  p_odd_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && $past(pi4_mode)) |-> (phase_idx[0] != prev_odd));

  p_even_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !$past(pi4_mode)) |-> !phase_idx[0]);

  p_lvl_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    i_lvl != 2'b10 && q_lvl != 2'b10 && (i_lvl != 2'b00 || q_lvl != 2'b00));

  p_axis_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_idx[0] |-> ((i_lvl == 2'b00) != (q_lvl == 2'b00)));
endmodule

bind dqpsk_symbol_encoder dqpsk_symbol_encoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pi4_mode(pi4_mode), .bit_req(bit_req),
  .sym_stb(sym_stb), .phase_idx(phase_idx), .i_lvl(i_lvl), .q_lvl(q_lvl)
);

// File: tb/test_dqpsk_symbol_encoder.sv
module test_dqpsk_symbol_encoder;
  localparam int SHORT = 8;
  localparam int LONG  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_in = 1'b0, pi4_mode = 1'b1, prbs_mode = 1'b0, slow_rate = 1'b0;
  logic bit_req, sym_stb;
  logic [2:0] phase_idx;
  logic [1:0] i_lvl, q_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] m_phase;
  bit         m_have_x;
  bit         m_x;
  logic [8:0] m_lfsr;

  always #2 clk = ~clk;

  dqpsk_symbol_encoder #(.SHORT_CLKS(SHORT), .LONG_CLKS(LONG)) i_dqpsk_symbol_encoder (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .pi4_mode(pi4_mode),
    .prbs_mode(prbs_mode), .slow_rate(slow_rate), .bit_req(bit_req),
    .sym_stb(sym_stb), .phase_idx(phase_idx), .i_lvl(i_lvl), .q_lvl(q_lvl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_i(input logic [2:0] p);
    if (p == 0 || p == 1 || p == 7) return 1;
    if (p == 2 || p == 6) return 0;
    return -1;
  endfunction

  function automatic int exp_q(input logic [2:0] p);
    if (p == 1 || p == 2 || p == 3) return 1;
    if (p == 0 || p == 4) return 0;
    return -1;
  endfunction

  function automatic int step_of(input bit x, input bit y, input bit p4);
    if (p4) return (!x && !y) ? 1 : (!x && y) ? 3 : (x && y) ? -3 : -1;
    return (!x && !y) ? 0 : (!x && y) ? 2 : (x && y) ? 4 : -2;
  endfunction

  task automatic do_reset(input bit slow);
    @(negedge clk);
    rst_n = 1'b0;
    slow_rate = slow;
    repeat (3) @(negedge clk);
    chk(phase_idx == 0, "R1", "phase in reset", phase_idx, 0);
    chk(!sym_stb, "R1", "sym_stb in reset", sym_stb, 0);
    chk(!bit_req, "R1", "bit_req in reset", bit_req, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    m_phase = 3'd0; m_have_x = 1'b0; m_x = 1'b0; m_lfsr = 9'h1FF;
    @(negedge clk);
    chk(bit_req, "R2", "first bit_req after release", bit_req, 1);
    chk($signed(i_lvl) == 1, "R1", "I after release", $signed(i_lvl), 1);
    chk($signed(q_lvl) == 0, "R1", "Q after release", $signed(q_lvl), 0);
  endtask

  // entered at the negedge of a bit_req cycle; leaves at the next one
  task automatic send_bit(input bit b, input bit strict, input string req);
    int n = slow_rate ? LONG : SHORT;
    int h = n / 2;
    bit used;
    bit due;
    used = prbs_mode ? m_lfsr[8] : b;
    m_lfsr = {m_lfsr[7:0], m_lfsr[8] ^ m_lfsr[4]};
    due = m_have_x;
    if (due) begin
      m_phase = 3'((pi4_mode ? int'(m_phase) : int'(m_phase & 3'd6))
                   + step_of(m_x, used, pi4_mode));
      m_have_x = 1'b0;
    end else begin
      m_x = used;
      m_have_x = 1'b1;
    end
    data_in = strict ? ~b : b;
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      if (k == h) data_in = b;
      if (k == h + 1 && strict) data_in = ~b;
      chk(!bit_req, "R2", "bit_req inside period", bit_req, 0);
      if (k == h + 1) begin
        chk(sym_stb == due, "R4", "symbol strobe after Y", sym_stb, due);
        if (due) begin
          chk(phase_idx == m_phase, req, "phase", phase_idx, m_phase);
          chk($signed(i_lvl) == exp_i(m_phase), "R7", "I level", $signed(i_lvl), exp_i(m_phase));
          chk($signed(q_lvl) == exp_q(m_phase), "R7", "Q level", $signed(q_lvl), exp_q(m_phase));
        end
      end else begin
        chk(!sym_stb, "R4", "no strobe", sym_stb, 0);
      end
    end
    @(negedge clk);
    chk(bit_req, "R2", "bit_req at period end", bit_req, 1);
  endtask

  task automatic send_pair(input bit x, input bit y, input bit strict, input string req);
    send_bit(x, strict, req);
    send_bit(y, strict, req);
  endtask

  task automatic t_pi4_steps;
    pi4_mode = 1'b1;
    for (int i = 0; i < 8; i++) send_pair(1'b0, 1'b0, 1'b0, "R5");
    send_pair(1'b0, 1'b1, 1'b0, "R5");
    send_pair(1'b1, 1'b1, 1'b0, "R5");
    send_pair(1'b1, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_plain_steps;
    pi4_mode = 1'b1;
    send_pair(1'b0, 1'b0, 1'b0, "R5");
    pi4_mode = 1'b0;
    send_pair(1'b0, 1'b0, 1'b0, "R6");
    send_pair(1'b0, 1'b1, 1'b0, "R6");
    send_pair(1'b1, 1'b1, 1'b0, "R6");
    send_pair(1'b1, 1'b0, 1'b0, "R6");
    chk(!phase_idx[0], "R6", "even phase in plain mode", phase_idx, phase_idx & 6);
  endtask

  task automatic t_midpoint;
    pi4_mode = 1'b1;
    send_pair(1'b0, 1'b1, 1'b1, "R3");
    send_pair(1'b1, 1'b0, 1'b1, "R3");
    send_pair(1'b1, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_prbs;
    prbs_mode = 1'b1;
    pi4_mode = 1'b1;
    for (int i = 0; i < 40; i++) send_bit(i[0] ^ i[2], 1'b0, "R8");
    pi4_mode = 1'b0;
    for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0, "R8");
    prbs_mode = 1'b0;
  endtask

  task automatic t_slow;
    do_reset(1'b1);
    pi4_mode = 1'b1;
    send_pair(1'b0, 1'b1, 1'b0, "R2");
    send_pair(1'b1, 1'b1, 1'b0, "R2");
    do_reset(1'b0);
  endtask

  task automatic t_mid_reset;
    prbs_mode = 1'b1;
    pi4_mode = 1'b1;
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, "R9");
    do_reset(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0, "R9");
    prbs_mode = 1'b0;
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, "R9");
    do_reset(1'b0);
    send_pair(1'b1, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    t_pi4_steps();
    t_plain_steps();
    t_midpoint();
    t_prbs();
    t_slow();
    t_mid_reset();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule